// File: doc/BRIEF.md
# Memory-to-Memory Move Processor

This block is a tiny processor with a single operation: it copies one memory word into another. There is no opcode and no arithmetic unit. Memory is read as a stream of address pairs, and each pair forms one instruction: the first word names the source location and the second names the destination. The processor fetches both words, copies the source word to the destination, and continues with the next pair. It never stops. The only way to change control flow is to let one move overwrite the address words of a later instruction.

The datapath contains a program counter, a memory address register and a temporary data register. A two-way selector puts either the program counter or the memory address register on the shared memory port. The memory port is synchronous with one cycle of read latency. For that reason every read takes two control steps: one step to issue the address and one step to capture the returned word. A complete move therefore takes seven clock cycles.

The word width and address width are parameters; both default to 16 bits. An address is taken from the low address-width bits of a fetched word.

Top module: `mmove_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following cycle shows `mem_we` low and `mem_addr` equal to 0. The program counter, address register and data register are all cleared. The first cycle after release issues address 0.
- R2: Each move occupies exactly seven cycles, counted from 0. In cycle 0 `mem_addr` carries the program counter (PC), in cycle 2 the source address, in cycle 4 PC+1, and in cycle 6 the destination address. Cycle 0 of the next move follows at once.
- R3: The program counter advances by exactly one after each address word is captured. A move therefore consumes two consecutive words, and the next move starts at PC+2.
- R4: The program counter wraps modulo 2^AW. The word after the highest address is address 0.
- R5: `mem_we` is high in exactly one cycle per move, cycle 6. In that cycle `mem_addr` is the destination address and `mem_wdata` is the full-width word read from the source address.
- R6: Source and destination addresses are the low AW bits of the fetched address words. Any higher bits are ignored.
- R7: With selector value 0 the memory address is the program counter; with value 1 it is the memory address register. The register is used for the data read and for the write.
- R8: Read data is taken one cycle after its address is issued, matching a synchronous memory with one cycle of latency.
- R9: A write into the address words of a later move takes effect when that move is fetched, which allows self-modifying jumps.
- R10: The processor has no halt state. After any number of moves the memory contents equal those of a sequential reference interpreter that runs the same number of moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Address to the shared memory port |
| mem_we | output | 1 | Write enable to the memory, one cycle per move |
| mem_wdata | output | DW | Word to be written |
| mem_rdata | input | DW | Word read by the memory, valid one cycle after its address |

## Verification
The assertions assume that `mem_rdata` comes from a memory with exactly one cycle of read latency and no other timing. They also assume that `rst` is synchronous and is held for at least one edge before the first check. The bench meets these assumptions with a behavioural memory that registers its read data on every edge. It drives reset and reloads memory only at falling edges. It uses a reduced 8-bit address configuration so that program-counter wraparound is reached within a few hundred moves. Memory contents come from computed patterns, so every address word, including the high bits above the address width, takes arbitrary values.

// File: rtl/mmove_pkg.sv
`timescale 1ns/1ps
package mmove_pkg;

  localparam int STEP_W         = 3;
  localparam int STEPS_PER_MOVE = 7;

  typedef enum logic [STEP_W-1:0] {
    ST_SRC_ADDR = 3'd0,
    ST_SRC_TAKE = 3'd1,
    ST_DAT_ADDR = 3'd2,
    ST_DAT_TAKE = 3'd3,
    ST_DST_ADDR = 3'd4,
    ST_DST_TAKE = 3'd5,
    ST_WRITE    = 3'd6
  } step_e;

  // Fixed ring of control steps; no halt.
  function automatic step_e next_step(input step_e s);
    case (s)
      ST_SRC_ADDR: return ST_SRC_TAKE;
      ST_SRC_TAKE: return ST_DAT_ADDR;
      ST_DAT_ADDR: return ST_DAT_TAKE;
      ST_DAT_TAKE: return ST_DST_ADDR;
      ST_DST_ADDR: return ST_DST_TAKE;
      ST_DST_TAKE: return ST_WRITE;
      default:     return ST_SRC_ADDR;
    endcase
  endfunction

endpackage

// File: rtl/mmove_ctrl.sv
`timescale 1ns/1ps
module mmove_ctrl
  import mmove_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output step_e step,
  output logic  ld_pc,
  output logic  ld_mar,
  output logic  ld_tmp,
  output logic  addr_sel,
  output logic  wr_en
);

  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_SRC_ADDR;
    else     step_q <= next_step(step_q);
  end

  assign step = step_q;

  // Decode: 0 selects PC, 1 selects MAR on the address bus.
  always_comb begin
    ld_pc    = 1'b0;
    ld_mar   = 1'b0;
    ld_tmp   = 1'b0;
    addr_sel = 1'b0;
    wr_en    = 1'b0;
    case (step_q)
      ST_SRC_ADDR: addr_sel = 1'b0;
      ST_SRC_TAKE: begin ld_mar = 1'b1; ld_pc = 1'b1; end
      ST_DAT_ADDR: addr_sel = 1'b1;
      ST_DAT_TAKE: begin addr_sel = 1'b1; ld_tmp = 1'b1; end
      ST_DST_ADDR: addr_sel = 1'b0;
      ST_DST_TAKE: begin ld_mar = 1'b1; ld_pc = 1'b1; end
      ST_WRITE:    begin addr_sel = 1'b1; wr_en = 1'b1; end
      default:     addr_sel = 1'b0;
    endcase
  end

endmodule

// File: rtl/mmove_addr_mux.sv
`timescale 1ns/1ps
module mmove_addr_mux #(
  parameter int AW = 16
) (
  input  logic          sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] mar,
  output logic [AW-1:0] addr
);

  always_comb begin
    if (sel) addr = mar;
    else     addr = pc;
  end

endmodule

// File: rtl/mmove_dpath.sv
`timescale 1ns/1ps
module mmove_dpath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_pc,
  input  logic          ld_mar,
  input  logic          ld_tmp,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] tmp_q
);

  // Wrapping increment by one word.
  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return AW'(a + 1'b1);
  endfunction

  // Address field of a fetched word: its low AW bits.
  function automatic logic [AW-1:0] word_to_addr(input logic [DW-1:0] w);
    return w[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      tmp_q <= '0;
    end else begin
      if (ld_pc)  pc_q  <= addr_inc(pc_q);
      if (ld_mar) mar_q <= word_to_addr(rdata);
      if (ld_tmp) tmp_q <= rdata;
    end
  end

endmodule

// File: rtl/mmove_core.sv
`timescale 1ns/1ps
module mmove_core
  import mmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  // Named internal events, visible to the bound checker.
  step_e         step;
  logic          ld_pc;
  logic          ld_mar;
  logic          ld_tmp;
  logic          addr_sel;
  logic          wr_en;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] tmp_q;

  mmove_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .ld_pc    (ld_pc),
    .ld_mar   (ld_mar),
    .ld_tmp   (ld_tmp),
    .addr_sel (addr_sel),
    .wr_en    (wr_en)
  );

  mmove_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ld_pc  (ld_pc),
    .ld_mar (ld_mar),
    .ld_tmp (ld_tmp),
    .rdata  (mem_rdata),
    .pc_q   (pc_q),
    .mar_q  (mar_q),
    .tmp_q  (tmp_q)
  );

  mmove_addr_mux #(.AW(AW)) u_mux (
    .sel  (addr_sel),
    .pc   (pc_q),
    .mar  (mar_q),
    .addr (mem_addr)
  );

  assign mem_we    = wr_en;
  assign mem_wdata = tmp_q;

endmodule

// File: rtl/mmove_core_chk.sv
`timescale 1ns/1ps
module mmove_core_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] mar_q,
  input logic [DW-1:0] tmp_q,
  input logic          ld_pc
);

  // R1: reset clears PC and quiets the write strobe
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !mem_we && mem_addr == '0));

  // R3: PC moves by one word on a load, otherwise holds
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> pc_q == AW'($past(pc_q) + 1'b1));

  a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_pc |=> $stable(pc_q));

  // R4: wrap from the top address to zero
  a_r4_pc_wrap: assert property (@(posedge clk) disable iff (rst)
    (ld_pc && pc_q == {AW{1'b1}}) |=> pc_q == '0);

  // R5: single-cycle write strobe carrying MAR and TEMP
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r5_write_bus: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == mar_q && mem_wdata == tmp_q));

  // R2: PC never advances in the write step
  a_r2_no_pc_on_write: assert property (@(posedge clk) disable iff (rst)
    !(ld_pc && mem_we));

  // R5: TEMP holds steady across the write
  a_r5_tmp_held: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(tmp_q));

endmodule

bind mmove_core mmove_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .pc_q      (pc_q),
  .mar_q     (mar_q),
  .tmp_q     (tmp_q),
  .ld_pc     (ld_pc)
);

// File: tb/mmove_core_test.sv
`timescale 1ns/1ps
module mmove_core_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  mmove_core #(.AW(AW), .DW(DW)) uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // Program patterns: seed 0 is a directed self-modifying program.
  function automatic logic [DW-1:0] pat(input int seed, input int i);
    logic [31:0] x;
    if (seed == 0) begin
      case (i)
        0:       return 16'h0010;
        1:       return 16'h0003;
        2:       return 16'h0011;
        3:       return 16'h0020;
        16'h10:  return 16'h1230;
        16'h11:  return 16'hBEEF;
        default: return 16'(i * 7 + 16'h5A00);
      endcase
    end
    x = 32'(i) * 32'h9E37_79B9 + 32'(seed) * 32'h7F4A_7C15;
    x = x ^ (x >> 13);
    return x[15:0] ^ x[31:16];
  endfunction

  // Behavioural memory: synchronous, one-cycle read latency.
  logic [DW-1:0] mem [NW];
  logic          ld_en = 1'b0;
  int            ld_seed = 0;

  always @(posedge clk) begin
    if (ld_en) begin
      for (int i = 0; i < NW; i++) mem[i] <= pat(ld_seed, i);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  // Reference interpreter state.
  logic [DW-1:0] ref_mem [NW];
  logic [AW-1:0] ref_pc;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R1: reset, reload, release
  task automatic load_prog(input int seed);
    @(negedge clk);
    rst     = 1'b1;
    ld_en   = 1'b1;
    ld_seed = seed;
    for (int i = 0; i < NW; i++) ref_mem[i] = pat(seed, i);
    ref_pc = '0;
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    chk(mem_we == 1'b0, "R1", "we in reset", int'(mem_we), 0);
    chk(mem_addr == '0, "R1", "addr in reset", int'(mem_addr), 0);
    rst = 1'b0;
    #1;
    chk(mem_addr == '0, "R1", "first fetch addr", int'(mem_addr), 0);
  endtask

  // One move: starts in cycle 0, ends in cycle 0 of the next move.
  task automatic run_move();
    logic [AW-1:0] src, dst, pc1;
    logic [DW-1:0] t;
    src = ref_mem[ref_pc][AW-1:0];       // R6: low AW bits
    t   = ref_mem[src];
    pc1 = AW'(ref_pc + 1'b1);
    dst = ref_mem[pc1][AW-1:0];
    for (int c = 0; c < 7; c++) begin
      if (c > 0) @(negedge clk);
      if (mem_we != (c == 6)) chk(1'b0, "R5", "we position", c, 6);
      case (c)
        0: chk(mem_addr == ref_pc, "R2 R4", "pc fetch addr", int'(mem_addr), int'(ref_pc));
        2: chk(mem_addr == src, "R6 R7", "source addr", int'(mem_addr), int'(src));
        4: chk(mem_addr == pc1, "R3", "dest word addr", int'(mem_addr), int'(pc1));
        6: begin
          chk(mem_we == 1'b1, "R5", "we in write step", int'(mem_we), 1);
          chk(mem_addr == dst, "R5", "write addr", int'(mem_addr), int'(dst));
          // R8: data captured one cycle after its address
          chk(mem_wdata == t, "R8", "write data", int'(mem_wdata), int'(t));
        end
        default: ;
      endcase
    end
    @(negedge clk);
    ref_mem[dst] = t;
    ref_pc = AW'(ref_pc + 2'd2);
  endtask

  task automatic compare_mem(input string tag);
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < NW; i++) begin
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, "R10", tag, bad, 0);
    if (bad != 0)
      $display("  first mismatch at %0h: %0h vs %0h", first, mem[first], ref_mem[first]);
  endtask

  initial begin
    // Directed self-modifying program (R9)
    load_prog(0);
    for (int k = 0; k < 2; k++) run_move();
    chk(mem[8'h03] == 16'h1230, "R9", "dest word patched", int'(mem[8'h03]), 16'h1230);
    chk(mem[8'h30] == 16'hBEEF, "R9", "redirected write", int'(mem[8'h30]), 16'hBEEF);
    chk(mem[8'h20] == 16'h5AE0, "R9", "old dest untouched", int'(mem[8'h20]), 16'h5AE0);
    compare_mem("directed program");

    // Pattern programs crossing the top address (R4, R10)
    load_prog(1);
    for (int k = 0; k < 140; k++) run_move();
    compare_mem("seed 1");

    // Reset mid-run restarts at address 0 (R1)
    load_prog(2);
    for (int k = 0; k < 60; k++) run_move();
    compare_mem("seed 2");

    load_prog(3);
    for (int k = 0; k < 300; k++) run_move();
    compare_mem("seed 3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule